// File: doc/BRIEF.md
# Answer-to-Reset Structure Parser

This block follows the byte stream that a smart-card receiver decodes after the synchronisation character of an answer-to-reset. It works out, one byte at a time, what each byte is: the format byte, an interface byte of a group (first, second, third or fourth kind), a historical byte or the trailing check byte. The length of the sequence is not known in advance. It is discovered as the bytes arrive, from the presence bitmap in the format byte and in each group's fourth byte. Whether a check byte closes the sequence depends on the protocol numbers those fourth bytes announce.

For every accepted byte the block emits a registered type tag. It pulses a completion flag with the last expected byte. It raises sticky flags for a check mismatch, for the reserved protocol value in the first group's protocol byte, and for a sequence that runs past the permitted length. It also holds the first group's rate byte and guard byte, and the first protocol offered, with their default values when those bytes are absent. A timing supervisor or the receiver issues a start pulse to begin each new parse.

Top module: `atr_frame_parser`

## Requirements
- R1: After reset all flags and `tag_valid` are 0, `rate_byte` is 0x11, `guard_byte` is 0 and `first_proto` is 0, and bytes offered before the first `start` give no tag.
- R2: The first byte accepted after `start` is tagged 0 (format). Its bits 7:4 announce the first group's bytes: bit 4 the first kind, bit 5 the second, bit 6 the third, bit 7 the fourth. Its bits 3:0 give the historical byte count K.
- R3: Interface bytes of a group are tagged in the fixed order 1, 2, 3, 4, and only those whose presence bit is set appear. A byte tagged 4 announces the next group with its bits 7:4 in the same layout, and carries a protocol number in bits 3:0.
- R4: After the last interface byte, exactly K bytes are tagged 5 (historical).
- R5: One byte tagged 6 (check) follows the historical bytes if and only if some byte tagged 4 carried a nonzero protocol number. `done` is high for exactly the cycle in which the last expected byte's tag is shown.
- R6: `chk_err` rises with the check byte's tag when the XOR of every byte from the format byte through the check byte is nonzero. It holds until the next `start`.
- R7: `proto_err` rises with the tag of the first group's fourth byte when that byte's bits 3:0 equal 15. It holds until `start`.
- R8: When a byte arrives after 32 bytes have been accepted and the sequence is not complete, `len_err` rises and no tag is shown. No further byte is tagged until `start`.
- R9: `rate_byte` and `guard_byte` take the first group's first-kind and third-kind bytes when present, and `first_proto` takes bits 3:0 of the first group's fourth byte.
- R10: `start` restarts the parse and clears the flags and latched fields. A byte offered in the same cycle as `start` is dropped, and bytes offered after completion are ignored.
- R11: Each tag and flag appears on the clock edge that accepts its byte, one cycle after the byte is offered. Idle cycles between bytes are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new parse |
| byte_valid | input | 1 | `byte_data` holds a decoded byte this cycle |
| byte_data | input | 8 | Decoded byte |
| tag_valid | output | 1 | `tag` describes the byte accepted on the last edge |
| tag | output | 3 | Byte type: 0 format, 1..4 interface kind, 5 historical, 6 check |
| done | output | 1 | Last expected byte accepted |
| chk_err | output | 1 | Check XOR mismatch, sticky |
| proto_err | output | 1 | Reserved protocol value in the first group, sticky |
| len_err | output | 1 | Length exceeded, sticky |
| rate_byte | output | 8 | First group's first-kind byte, or 0x11 |
| guard_byte | output | 8 | First group's third-kind byte, or 0 |
| first_proto | output | 4 | Protocol of the first group's fourth byte, or 0 |

## Verification
Two pairs of functions can fall in the same cycle. The completion pulse and the mismatch flag both land on the check byte's edge. The bench sends sequences with a correct check byte and with a corrupted one, and requires `done` in both cases with `chk_err` only in the second. A restart can also collide with an offered byte. The bench raises `start` together with a valid byte, both mid-sequence and at the beginning, and judges that no tag appears and that the next byte is taken as the format byte. A behavioural model built on a queue of pending byte kinds predicts every output on every clock, so a tag or flag that moves by one cycle is reported.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [2:0] {
    TAG_FMT  = 3'd0,
    TAG_A    = 3'd1,
    TAG_B    = 3'd2,
    TAG_C    = 3'd3,
    TAG_D    = 3'd4,
    TAG_HIST = 3'd5,
    TAG_CHK  = 3'd6
  } atr_tag_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FMT,
    PH_IFACE,
    PH_HIST,
    PH_CHECK,
    PH_FIN
  } atr_phase_e;
endpackage

// File: rtl/atr_xor_acc.sv
module atr_xor_acc #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] acc_next
);
  logic [DATA_W-1:0] acc_q;

  assign acc_next = acc_q ^ din;

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (en)      acc_q <= acc_next;
  end
endmodule

// File: rtl/atr_cursor.sv
module atr_cursor
  import atr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 32,
  localparam int NIB    = DATA_W / 2,
  localparam int SEL_W  = $clog2(NIB),
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  output logic              take,
  output logic              ovf,
  output logic              last,
  output logic              in_group1,
  output atr_tag_e          cur_tag
);
  atr_phase_e       phase, nxt;
  logic [NIB-1:0]   pend, pend_n;
  logic [NIB-1:0]   hist, hist_n;
  logic             need_tck, tck_n;
  logic             first_q, first_n;
  logic [CNT_W-1:0] count;
  logic [SEL_W-1:0] sel;
  logic             active;

  localparam logic [SEL_W-1:0] SEL_D = SEL_W'(NIB - 1);

  assign active    = (phase != PH_IDLE) && (phase != PH_FIN);
  assign ovf       = byte_valid && !start && active && (count == CNT_W'(MAX_LEN));
  assign take      = byte_valid && !start && active && !ovf;
  assign in_group1 = first_q;

  // lowest pending presence bit wins: fixed kind order within a group
  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NIB; i++) begin
      if (pend[i] && !found) begin
        sel   = SEL_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    pend_n  = pend;
    hist_n  = hist;
    tck_n   = need_tck;
    first_n = first_q;
    cur_tag = TAG_FMT;
    unique case (phase)
      PH_FMT: begin
        cur_tag = TAG_FMT;
        pend_n  = byte_data[DATA_W-1:NIB];
        hist_n  = byte_data[NIB-1:0];
      end
      PH_IFACE: begin
        cur_tag = atr_tag_e'(3'(sel) + 3'd1);
        if (sel == SEL_D) begin
          pend_n  = byte_data[DATA_W-1:NIB];
          first_n = 1'b0;
          if (byte_data[NIB-1:0] != '0) tck_n = 1'b1;
        end else begin
          pend_n = pend & ~(NIB'(1) << sel);
        end
      end
      PH_HIST: begin
        cur_tag = TAG_HIST;
        hist_n  = hist - NIB'(1);
      end
      PH_CHECK: cur_tag = TAG_CHK;
      default: ;
    endcase

    if (phase == PH_CHECK)  nxt = PH_FIN;
    else if (pend_n != '0)  nxt = PH_IFACE;
    else if (hist_n != '0)  nxt = PH_HIST;
    else if (tck_n)         nxt = PH_CHECK;
    else                    nxt = PH_FIN;
    last = (nxt == PH_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      pend     <= '0;
      hist     <= '0;
      need_tck <= 1'b0;
      first_q  <= 1'b1;
      count    <= '0;
    end else if (start) begin
      phase    <= PH_FMT;
      pend     <= '0;
      hist     <= '0;
      need_tck <= 1'b0;
      first_q  <= 1'b1;
      count    <= '0;
    end else if (ovf) begin
      phase <= PH_FIN;
    end else if (take) begin
      phase    <= nxt;
      pend     <= pend_n;
      hist     <= hist_n;
      need_tck <= tck_n;
      first_q  <= first_n;
      count    <= count + CNT_W'(1);
    end
  end

  assert_len_bound_R8: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(MAX_LEN));

  assert_stop_after_ovf_R8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (phase == PH_FIN) || start);
endmodule

// File: rtl/atr_field_latch.sv
module atr_field_latch
  import atr_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter logic [DATA_W-1:0] RATE_DFLT = 8'h11,
  localparam int             NIB        = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              take,
  input  logic              in_group1,
  input  atr_tag_e          cur_tag,
  input  logic [DATA_W-1:0] byte_data,
  output logic [DATA_W-1:0] rate_q,
  output logic [DATA_W-1:0] guard_q,
  output logic [NIB-1:0]    proto_q,
  output logic              proto_bad_q
);
  localparam logic [NIB-1:0] PROTO_RSV = '1;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      rate_q      <= RATE_DFLT;
      guard_q     <= '0;
      proto_q     <= '0;
      proto_bad_q <= 1'b0;
    end else if (take && in_group1) begin
      if (cur_tag == TAG_A) rate_q  <= byte_data;
      if (cur_tag == TAG_C) guard_q <= byte_data;
      if (cur_tag == TAG_D) begin
        proto_q <= byte_data[NIB-1:0];
        if (byte_data[NIB-1:0] == PROTO_RSV) proto_bad_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/atr_frame_parser.sv
module atr_frame_parser
  import atr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MAX_LEN = 32,
  localparam int NIB    = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  output logic              tag_valid,
  output logic [2:0]        tag,
  output logic              done,
  output logic              chk_err,
  output logic              proto_err,
  output logic              len_err,
  output logic [DATA_W-1:0] rate_byte,
  output logic [DATA_W-1:0] guard_byte,
  output logic [NIB-1:0]    first_proto
);
  logic              take, ovf, last, in_group1;
  atr_tag_e          cur_tag;
  logic [DATA_W-1:0] acc_next;
  atr_tag_e          tag_q;

  atr_cursor #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u_cursor (
    .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid),
    .byte_data(byte_data), .take(take), .ovf(ovf), .last(last),
    .in_group1(in_group1), .cur_tag(cur_tag)
  );

  atr_xor_acc #(.DATA_W(DATA_W)) u_xor (
    .clk(clk), .rst(rst), .clear(start), .en(take),
    .din(byte_data), .acc_next(acc_next)
  );

  atr_field_latch #(.DATA_W(DATA_W)) u_fields (
    .clk(clk), .rst(rst), .start(start), .take(take),
    .in_group1(in_group1), .cur_tag(cur_tag), .byte_data(byte_data),
    .rate_q(rate_byte), .guard_q(guard_byte), .proto_q(first_proto),
    .proto_bad_q(proto_err)
  );

  always_ff @(posedge clk) begin
    if (rst || start) begin
      tag_valid <= 1'b0;
      tag_q     <= TAG_FMT;
      done      <= 1'b0;
      chk_err   <= 1'b0;
      len_err   <= 1'b0;
    end else begin
      tag_valid <= take;
      done      <= take && last;
      if (take) tag_q <= cur_tag;
      if (take && cur_tag == TAG_CHK && acc_next != '0) chk_err <= 1'b1;
      if (ovf) len_err <= 1'b1;
    end
  end

  assign tag = tag_q;

  assert_done_with_tag_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> tag_valid);

  assert_mismatch_on_check_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(chk_err) |-> tag_valid && tag == TAG_CHK && done);

  assert_proto_flag_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(proto_err) |-> tag_valid && tag == TAG_D && first_proto == '1);

  assert_no_tag_on_ovf_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(len_err) |-> !tag_valid && !done);

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
    start |=> !tag_valid && !len_err && !chk_err);
endmodule

// File: tb/atr_frame_parser_test.sv
module atr_frame_parser_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       tag_valid, done, chk_err, proto_err, len_err;
  logic [2:0] tag;
  logic [7:0] rate_byte, guard_byte;
  logic [3:0] first_proto;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  atr_frame_parser uut (
    .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid),
    .byte_data(byte_data), .tag_valid(tag_valid), .tag(tag), .done(done),
    .chk_err(chk_err), .proto_err(proto_err), .len_err(len_err),
    .rate_byte(rate_byte), .guard_byte(guard_byte), .first_proto(first_proto)
  );

  // ---------------- behavioural reference ----------------
  int m_on = 0, m_fmt = 0, m_hist = 0, m_tck = 0, m_first = 0, m_cnt = 0;
  int m_xor = 0;
  int m_q[$];
  logic       e_tv = 0, e_dn = 0, e_chk = 0, e_perr = 0, e_len = 0;
  logic [2:0] e_tag = 0;
  logic [7:0] e_ta = 8'h11, e_tc = 0;
  logic [3:0] e_pr = 0;

  task automatic push_group(input int b);
    for (int k = 0; k < 4; k++) if (b[4+k]) m_q.push_back(k + 1);
  endtask

  always @(posedge clk) begin
    if (rst || start) begin
      m_on = start ? 1 : 0; m_fmt = 1; m_hist = 0; m_tck = 0; m_first = 1;
      m_cnt = 0; m_xor = 0; m_q.delete();
      e_tv <= 0; e_dn <= 0; e_chk <= 0; e_perr <= 0; e_len <= 0;
      e_ta <= 8'h11; e_tc <= 0; e_pr <= 0;
    end else if (byte_valid && m_on != 0) begin
      if (m_cnt == 32) begin
        e_len <= 1; e_tv <= 0; e_dn <= 0; m_on = 0;
      end else begin
        int d, t, last;
        d = int'(byte_data); m_cnt++; m_xor = m_xor ^ d;
        if (m_fmt != 0) begin
          t = 0; m_fmt = 0; m_hist = d & 15; push_group(d);
        end else if (m_q.size() > 0) begin
          t = m_q.pop_front();
          if (m_first != 0 && t == 1) e_ta <= byte_data;
          if (m_first != 0 && t == 3) e_tc <= byte_data;
          if (t == 4) begin
            if (m_first != 0) begin
              e_pr <= byte_data[3:0];
              if ((d & 15) == 15) e_perr <= 1;
            end
            m_first = 0;
            if ((d & 15) != 0) m_tck = 1;
            push_group(d);
          end
        end else if (m_hist > 0) begin
          t = 5; m_hist--;
        end else begin
          t = 6;
          if (m_xor != 0) e_chk <= 1;
        end
        last = (t == 6) ? 1 : ((m_q.size() == 0 && m_hist == 0 && m_tck == 0) ? 1 : 0);
        if (last != 0) m_on = 0;
        e_tv <= 1; e_tag <= 3'(t); e_dn <= (last != 0);
      end
    end else begin
      e_tv <= 0; e_dn <= 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_req(input logic [2:0] t);
    case (t)
      3'd0:          return "R2 tag";
      3'd5:          return "R4 tag";
      3'd6:          return "R5 tag";
      default:       return "R3 tag";
    endcase
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check("R11 tag_valid", int'(tag_valid), int'(e_tv));
      if (e_tv) check(tag_req(e_tag), int'(tag), int'(e_tag));
      check("R5 done", int'(done), int'(e_dn));
      check("R6 chk_err", int'(chk_err), int'(e_chk));
      check("R7 proto_err", int'(proto_err), int'(e_perr));
      check("R8 len_err", int'(len_err), int'(e_len));
      check("R9 rate_byte", int'(rate_byte), int'(e_ta));
      check("R9 guard_byte", int'(guard_byte), int'(e_tc));
      check("R9 first_proto", int'(first_proto), int'(e_pr));
    end
    if (cycles > 20000) begin
      fails++; total++;
      $display("FAIL R5 watchdog cycles=%0d expected=below 20000", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_valid = 1'b0;
    end
  endtask

  task automatic kick(input logic with_byte, input logic [7:0] b);
    @(negedge clk); start = 1'b1; byte_valid = with_byte; byte_data = b;
    @(negedge clk); start = 1'b0; byte_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] seq[$], input int gap);
    foreach (seq[i]) begin
      put(seq[i]);
      if (gap > 0) idle(gap);
    end
    idle(1);
  endtask

  function automatic logic [7:0] xsum(input logic [7:0] seq[$]);
    logic [7:0] x = 8'h00;
    foreach (seq[i]) x ^= seq[i];
    return x;
  endfunction

  initial begin
    logic [7:0] s[$];
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1 reset tag_valid", int'(tag_valid), 0);
    check("R1 reset rate_byte", int'(rate_byte), 8'h11);
    check("R1 reset guard_byte", int'(guard_byte), 0);
    put(8'h75); idle(1);
    check("R1 byte before start no tag", int'(tag_valid), 0);

    // format byte alone completes
    kick(1'b0, 8'h00);
    send('{8'h00}, 0);
    check("R2 lone format byte done", int'(done), 1);

    // three first-group bytes and five historical bytes, no check byte
    kick(1'b0, 8'h00);
    send('{8'h75, 8'h95, 8'h00, 8'h10, 8'h41, 8'h42, 8'h43, 8'h44, 8'h45}, 0);
    check("R4 historical end done", int'(done), 1);
    check("R9 rate latched", int'(rate_byte), 8'h95);
    check("R9 guard latched", int'(guard_byte), 8'h10);

    // chained groups with protocol 1, correct check byte, gaps between bytes
    kick(1'b0, 8'h00);
    s = '{8'h80, 8'h81, 8'h31, 8'hFE, 8'h45};
    s.push_back(xsum(s));
    send(s, 2);
    check("R6 good check byte", int'(chk_err), 0);
    check("R5 check byte done", int'(done), 0);

    // corrupted check byte: done and mismatch together
    kick(1'b0, 8'h00);
    s = '{8'h80, 8'h81, 8'h31, 8'hFE, 8'h45};
    s.push_back(xsum(s) ^ 8'h01);
    send(s, 0);
    check("R6 bad check byte", int'(chk_err), 1);
    put(8'h12); idle(1);
    check("R10 byte after done ignored", int'(tag_valid), 0);

    // reserved protocol in first group
    kick(1'b0, 8'h00);
    s = '{8'h80, 8'h0F};
    s.push_back(xsum(s));
    send(s, 0);
    check("R7 reserved protocol flag", int'(proto_err), 1);

    // start colliding with a byte, then start mid-sequence
    kick(1'b1, 8'h80);
    check("R10 byte with start dropped", int'(tag_valid), 0);
    put(8'h13); idle(1);
    check("R10 next byte is format", int'(tag), 0);
    put(8'h22);
    kick(1'b1, 8'h33);
    check("R10 restart clears", int'(rate_byte), 8'h11);
    send('{8'h10, 8'h96}, 0);
    check("R10 restart parse done", int'(done), 1);

    // length overflow: format byte plus a chain of group bytes
    kick(1'b0, 8'h00);
    for (int i = 0; i < 33; i++) put(8'h80);
    idle(1);
    check("R8 overflow flag", int'(len_err), 1);
    put(8'h00); idle(1);
    check("R8 no tag after overflow", int'(tag_valid), 0);

    idle(2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule